// File: doc/BRIEF.md
# Two-Level I/O Address Translator

This block turns addresses issued by DMA-capable devices into physical memory addresses. It walks two tables: a segment table selected by the top bits of the device address, then a page table belonging to the chosen segment. Each segment picks its own page size and its own page-table length. Each page entry carries a real page number, separate read and write grants and an I/O identifier.

Both tables live in a word-addressed memory inside the block. Each word is 64 bits and a table page is 512 words. Software fills the memory through a write port. It programs a table-origin register and a configuration register, which hold the table enable and the global translation enable. Devices then present requests on a valid/ready handshake. Each request gets exactly one response: a physical address, or a fault code. A one-cycle fault pulse goes to an exception logger. While translation is off, addresses pass through untouched.

Top module: `iova_xlate`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid and flt_pulse are 0, and both the table enable and the translation enable are clear, so the first request bypasses the tables.
- R2: The translation enable is bit 47 of the configuration register (reg_sel=1). While it is clear, a request is answered on the first cycle after acceptance. rsp_pa then equals req_addr zero-extended, rsp_fault is 0 (none) and rsp_ioid is 0.
- R3: The table enable is bit 63 of the origin register (reg_sel=0). If translation is on and this bit is clear, every request ends with rsp_fault=1 (segment fault).
- R4: The segment index is req_addr >> 28. The segment entry is read from word (origin bits 61:12)*512 + index. If bit 63 of that entry is clear, the result is a segment fault.
- R5: Segment-entry bits 2:0 select the page size: 1 gives 4 KB, 3 gives 64 KB, 5 gives 1 MB and 7 gives 16 MB. Any other code gives a segment fault.
- R6: The page index is (req_addr mod 256 MB) shifted right by the page-size bits. It must be below (segment-entry bits 11:5 + 1) * 512, or else rsp_fault=2 (page fault).
- R7: The page entry is read from word (segment-entry bits 61:12)*512 + page index.
- R8: A write request (req_write=1) needs page-entry bit 63. A read needs bit 62. If the needed bit is missing, the result is a page fault.
- R9: On success, rsp_pa takes the page-entry bits PA_W-1:12 above the page size and the req_addr bits below it. rsp_ioid is page-entry bits 10:0.
- R10: While rsp_valid is high and rsp_ready is low, rsp_valid, rsp_pa, rsp_fault and rsp_ioid hold steady. req_ready is high only when no request is in flight.
- R11: flt_pulse is high for exactly the first cycle of every faulting response, and at no other time.
- R12: A tbl_we write stores tbl_wdata at word tbl_waddr. Later walks use the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects origin, 1 selects configuration |
| reg_wdata | input | 64 | Register write data |
| tbl_we | input | 1 | Table memory write strobe |
| tbl_waddr | input | MEM_AW | Table memory word address |
| tbl_wdata | input | 64 | Table memory write data |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block idle and able to accept |
| req_addr | input | DMA_W | Device address |
| req_write | input | 1 | 1 for a device write, 0 for a read |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_pa | output | PA_W | Physical address |
| rsp_fault | output | 2 | 0 none, 1 segment fault, 2 page fault |
| rsp_ioid | output | 11 | I/O identifier from the page entry |
| flt_pulse | output | 1 | One-cycle fault notice |

## Verification
The assertions assume a few things about the environment. The table memory and the registers are not rewritten while a walk is in flight. req_addr and req_write are steady in the cycle a request is accepted. The bench meets this by loading all tables and registers between transactions, never during a walk. It also drives each request for exactly one accepted cycle. rsp_ready is either pulsed once or held low on purpose to test the hold rule.

// File: rtl/iova_pkg.sv
package iova_pkg;
  localparam int SEG_SHIFT = 28;
  localparam int TPG_LG    = 9;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_SEG  = 2'd1,
    FLT_PAGE = 2'd2
  } flt_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEG  = 2'd1,
    ST_PTE  = 2'd2,
    ST_RESP = 2'd3
  } st_e;

  function automatic logic [4:0] page_shift(input logic [2:0] code);
    case (code)
      3'd1:    page_shift = 5'd12;
      3'd3:    page_shift = 5'd16;
      3'd5:    page_shift = 5'd20;
      3'd7:    page_shift = 5'd24;
      default: page_shift = 5'd0;
    endcase
  endfunction
endpackage

// File: rtl/iova_cfg_regs.sv
module iova_cfg_regs #(
  parameter int PNL = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic           reg_sel,
  input  logic [63:0]    reg_wdata,
  output logic           tbl_en,
  output logic [PNL-1:0] tbl_pn,
  output logic           xlate_en
);
  logic           org_en_q, org_en_d;
  logic [PNL-1:0] org_pn_q, org_pn_d;
  logic           te_q, te_d;
  logic           org_ld, cfg_ld;
  logic           unused_wbits;

  assign org_ld = reg_we && !reg_sel;
  assign cfg_ld = reg_we && reg_sel;

  always_comb begin
    org_en_d = org_en_q;
    org_pn_d = org_pn_q;
    te_d     = te_q;
    if (org_ld) begin
      org_en_d = reg_wdata[63];
      org_pn_d = reg_wdata[12 +: PNL];
    end
    if (cfg_ld) te_d = reg_wdata[47];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      org_en_q <= 1'b0;
      org_pn_q <= '0;
      te_q     <= 1'b0;
    end else begin
      org_en_q <= org_en_d;
      org_pn_q <= org_pn_d;
      te_q     <= te_d;
    end
  end

  assign tbl_en   = org_en_q;
  assign tbl_pn   = org_pn_q;
  assign xlate_en = te_q;
  assign unused_wbits = ^{reg_wdata[62:48], reg_wdata[46:12+PNL], reg_wdata[11:0]};

  assert_cfg_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> $stable(xlate_en) && $stable(tbl_en));
endmodule

// File: rtl/iova_tbl_mem.sv
module iova_tbl_mem #(
  parameter int MEM_AW = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [MEM_AW-1:0] waddr,
  input  logic [63:0]       wdata,
  input  logic              re,
  input  logic [MEM_AW-1:0] raddr,
  output logic [63:0]       rdata
);
  localparam int DEPTH = 1 << MEM_AW;
  logic [63:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/iova_walker.sv
module iova_walker
  import iova_pkg::*;
#(
  parameter int DMA_W  = 32,
  parameter int PA_W   = 42,
  parameter int MEM_AW = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xlate_en,
  input  logic              tbl_en,
  input  logic [MEM_AW-TPG_LG-1:0] tbl_pn,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [DMA_W-1:0]  req_addr,
  input  logic              req_write,
  output logic              mem_re,
  output logic [MEM_AW-1:0] mem_raddr,
  input  logic [63:0]       mem_rdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PA_W-1:0]   rsp_pa,
  output logic [1:0]        rsp_fault,
  output logic [10:0]       rsp_ioid,
  output logic              flt_pulse
);
  localparam int PNL   = MEM_AW - TPG_LG;
  localparam int SEG_W = DMA_W - SEG_SHIFT;

  st_e              st_q, st_d;
  logic [DMA_W-1:0] addr_q;
  logic             wr_q;
  logic [4:0]       sh_q, sh_d;
  logic [PA_W-1:0]  pa_q, pa_d;
  flt_e             flt_q, flt_d;
  logic [10:0]      ioid_q, ioid_d;
  logic             pls_q, pls_d;
  logic             cap_en, res_en;

  logic [4:0]       se_sh;
  logic [27:0]      pg_idx;
  logic [16:0]      pg_lim;
  logic             need_ok;
  logic [PA_W-1:0]  off_m;
  logic [PA_W-1:0]  pa_walk;
  logic [SEG_W-1:0] seg_idx;
  logic             unused_rbits;

  assign seg_idx = req_addr[DMA_W-1:SEG_SHIFT];
  assign se_sh   = page_shift(mem_rdata[2:0]);
  assign pg_idx  = addr_q[SEG_SHIFT-1:0] >> se_sh;
  assign pg_lim  = ({10'd0, mem_rdata[11:5]} + 17'd1) << TPG_LG;
  assign need_ok = wr_q ? mem_rdata[63] : mem_rdata[62];
  assign off_m   = (PA_W'(1) << sh_q) - PA_W'(1);
  assign pa_walk = ({mem_rdata[PA_W-1:12], 12'd0} & ~off_m) | (PA_W'(addr_q) & off_m);
  assign unused_rbits = ^{mem_rdata[61:PA_W], mem_rdata[11], mem_rdata[4:3],
                          mem_rdata[12+PNL +: 2]};

  always_comb begin
    st_d      = st_q;
    sh_d      = sh_q;
    pa_d      = pa_q;
    flt_d     = flt_q;
    ioid_d    = ioid_q;
    pls_d     = 1'b0;
    mem_re    = 1'b0;
    mem_raddr = '0;
    cap_en    = 1'b0;
    res_en    = 1'b0;
    case (st_q)
      ST_IDLE: if (req_valid) begin
        cap_en = 1'b1;
        if (!xlate_en) begin
          st_d = ST_RESP; res_en = 1'b1;
          pa_d = PA_W'(req_addr); flt_d = FLT_NONE; ioid_d = '0;
        end else if (!tbl_en) begin
          st_d = ST_RESP; res_en = 1'b1; pls_d = 1'b1;
          pa_d = '0; flt_d = FLT_SEG; ioid_d = '0;
        end else begin
          mem_re    = 1'b1;
          mem_raddr = {tbl_pn, {TPG_LG{1'b0}}} + MEM_AW'(seg_idx);
          st_d      = ST_SEG;
        end
      end
      ST_SEG: begin
        if (!mem_rdata[63] || se_sh == 5'd0) begin
          st_d = ST_RESP; res_en = 1'b1; pls_d = 1'b1;
          pa_d = '0; flt_d = FLT_SEG; ioid_d = '0;
        end else if (pg_idx >= {11'd0, pg_lim}) begin
          st_d = ST_RESP; res_en = 1'b1; pls_d = 1'b1;
          pa_d = '0; flt_d = FLT_PAGE; ioid_d = '0;
        end else begin
          mem_re    = 1'b1;
          mem_raddr = {mem_rdata[12 +: PNL], {TPG_LG{1'b0}}} + pg_idx[MEM_AW-1:0];
          sh_d      = se_sh;
          st_d      = ST_PTE;
        end
      end
      ST_PTE: begin
        st_d = ST_RESP; res_en = 1'b1;
        if (!need_ok) begin
          pls_d = 1'b1; pa_d = '0; flt_d = FLT_PAGE; ioid_d = '0;
        end else begin
          pa_d = pa_walk; flt_d = FLT_NONE; ioid_d = mem_rdata[10:0];
        end
      end
      default: if (rsp_ready) st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      wr_q   <= 1'b0;
      sh_q   <= '0;
      pa_q   <= '0;
      flt_q  <= FLT_NONE;
      ioid_q <= '0;
      pls_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      sh_q  <= sh_d;
      pls_q <= pls_d;
      if (cap_en) begin
        addr_q <= req_addr;
        wr_q   <= req_write;
      end
      if (res_en) begin
        pa_q   <= pa_d;
        flt_q  <= flt_d;
        ioid_q <= ioid_d;
      end
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign rsp_valid = (st_q == ST_RESP);
  assign rsp_pa    = pa_q;
  assign rsp_fault = flt_q;
  assign rsp_ioid  = ioid_q;
  assign flt_pulse = pls_q;

  assert_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !xlate_en) |=>
      rsp_valid && rsp_fault == FLT_NONE && rsp_pa == PA_W'($past(req_addr)));

  assert_origin_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && xlate_en && !tbl_en) |=> rsp_valid && rsp_fault == FLT_SEG);

  assert_seg_invalid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SEG && !mem_rdata[63]) |=> rsp_valid && rsp_fault == FLT_SEG);

  assert_perm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PTE && !need_ok) |=> rsp_fault == FLT_PAGE);

  assert_offset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == FLT_NONE) |-> rsp_pa[11:0] == addr_q[11:0]);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      rsp_valid && $stable(rsp_pa) && $stable(rsp_fault) && $stable(rsp_ioid));

  assert_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flt_pulse |-> rsp_valid && rsp_fault != FLT_NONE);
endmodule

// File: rtl/iova_xlate.sv
module iova_xlate
  import iova_pkg::*;
#(
  parameter int DMA_W  = 32,
  parameter int PA_W   = 42,
  parameter int MEM_AW = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_sel,
  input  logic [63:0]       reg_wdata,
  input  logic              tbl_we,
  input  logic [MEM_AW-1:0] tbl_waddr,
  input  logic [63:0]       tbl_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [DMA_W-1:0]  req_addr,
  input  logic              req_write,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PA_W-1:0]   rsp_pa,
  output logic [1:0]        rsp_fault,
  output logic [10:0]       rsp_ioid,
  output logic              flt_pulse
);
  localparam int PNL = MEM_AW - TPG_LG;

  logic [1:0]        rst_sync_q;
  logic              rst_n_s;
  logic              tbl_en, xlate_en;
  logic [PNL-1:0]    tbl_pn;
  logic              mem_re;
  logic [MEM_AW-1:0] mem_raddr;
  logic [63:0]       mem_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  iova_cfg_regs #(.PNL(PNL)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .tbl_en(tbl_en), .tbl_pn(tbl_pn), .xlate_en(xlate_en)
  );

  iova_tbl_mem #(.MEM_AW(MEM_AW)) u_mem (
    .clk(clk), .we(tbl_we), .waddr(tbl_waddr), .wdata(tbl_wdata),
    .re(mem_re), .raddr(mem_raddr), .rdata(mem_rdata)
  );

  iova_walker #(.DMA_W(DMA_W), .PA_W(PA_W), .MEM_AW(MEM_AW)) u_walk (
    .clk(clk), .rst_n(rst_n_s), .xlate_en(xlate_en), .tbl_en(tbl_en), .tbl_pn(tbl_pn),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .mem_re(mem_re), .mem_raddr(mem_raddr),
    .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_pa(rsp_pa), .rsp_fault(rsp_fault), .rsp_ioid(rsp_ioid), .flt_pulse(flt_pulse)
  );
endmodule

// File: tb/sim_iova_xlate.sv
module sim_iova_xlate;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we, reg_sel;
  logic [63:0] reg_wdata;
  logic        tbl_we;
  logic [10:0] tbl_waddr;
  logic [63:0] tbl_wdata;
  logic        req_valid, req_ready, req_write;
  logic [31:0] req_addr;
  logic        rsp_valid, rsp_ready;
  logic [41:0] rsp_pa;
  logic [1:0]  rsp_fault;
  logic [10:0] rsp_ioid;
  logic        flt_pulse;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  iova_xlate u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_pa(rsp_pa), .rsp_fault(rsp_fault), .rsp_ioid(rsp_ioid), .flt_pulse(flt_pulse)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_tbl(input logic [10:0] a, input logic [63:0] d);
    @(negedge clk); tbl_we = 1'b1; tbl_waddr = a; tbl_wdata = d;
    @(negedge clk); tbl_we = 1'b0;
  endtask

  task automatic wr_reg(input logic sel, input logic [63:0] d);
    @(negedge clk); reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic xlate(input logic [31:0] a, input logic w, input int hold,
                       output logic [41:0] pa, output logic [1:0] f,
                       output logic [10:0] io, output logic pls, output int lat);
    @(negedge clk); req_addr = a; req_write = w; req_valid = 1'b1;
    @(posedge clk); #1 req_valid = 1'b0;
    lat = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); lat++;
      if (rsp_valid) break;
    end
    pa = rsp_pa; f = rsp_fault; io = rsp_ioid; pls = flt_pulse;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      chk("R10 hold valid", 64'(rsp_valid), 64'd1);
      chk("R10 hold pa", 64'(rsp_pa), 64'(pa));
      chk("R11 single pulse", 64'(flt_pulse), 64'd0);
      chk("R10 busy no ready", 64'(req_ready), 64'd0);
    end
    rsp_ready = 1'b1;
    @(posedge clk); #1 rsp_ready = 1'b0;
  endtask

  logic [41:0] pa;
  logic [1:0]  f;
  logic [10:0] io;
  logic        pls;
  int          lat;

  task automatic t_reset();
    @(negedge clk);
    chk("R1 ready", 64'(req_ready), 64'd1);
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1 flt_pulse", 64'(flt_pulse), 64'd0);
    xlate(32'h1234_5678, 1'b0, 0, pa, f, io, pls, lat);
    chk("R1 bypass after reset", 64'(pa), 64'h1234_5678);
  endtask

  task automatic t_load();
    wr_tbl(11'd0,    64'h8000_0000_0000_1001);
    wr_tbl(11'd1,    64'h0000_0000_0000_0000);
    wr_tbl(11'd2,    64'h8000_0000_0000_2003);
    wr_tbl(11'd3,    64'h8000_0000_0000_3007);
    wr_tbl(11'd4,    64'h8000_0000_0000_3002);
    wr_tbl(11'd6,    64'h8000_0000_0000_2021);
    wr_tbl(11'd512,  64'hC000_0000_1234_502A);
    wr_tbl(11'd513,  64'h4000_0000_0077_7005);
    wr_tbl(11'd1027, 64'h8000_0000_0ABC_F011);
    wr_tbl(11'd1536, 64'hC000_0000_0099_9003);
    wr_tbl(11'd1537, 64'hC000_0002_3F00_07FF);
  endtask

  task automatic t_bypass();
    wr_reg(1'b0, 64'h8000_0000_0000_0000);
    wr_reg(1'b1, 64'h0);
    xlate(32'hF00D_0ABC, 1'b1, 0, pa, f, io, pls, lat);
    chk("R2 bypass pa", 64'(pa), 64'hF00D_0ABC);
    chk("R2 bypass fault", 64'(f), 64'd0);
    chk("R2 bypass ioid", 64'(io), 64'd0);
    chk("R2 bypass latency", 64'(lat), 64'd1);
  endtask

  task automatic t_origin_off();
    wr_reg(1'b0, 64'h0);
    wr_reg(1'b1, 64'h0000_8000_0000_0000);
    xlate(32'h0000_0ABC, 1'b0, 0, pa, f, io, pls, lat);
    chk("R3 origin off fault", 64'(f), 64'd1);
    chk("R11 pulse origin off", 64'(pls), 64'd1);
    wr_reg(1'b0, 64'h8000_0000_0000_0000);
  endtask

  task automatic t_4k();
    xlate(32'h0000_0ABC, 1'b0, 0, pa, f, io, pls, lat);
    chk("R9 4K pa", 64'(pa), 64'h1234_5ABC);
    chk("R9 4K ioid", 64'(io), 64'h02A);
    chk("R7 fault none", 64'(f), 64'd0);
    chk("R11 no pulse ok", 64'(pls), 64'd0);
    xlate(32'h0000_1234, 1'b0, 0, pa, f, io, pls, lat);
    chk("R7 idx1 pa", 64'(pa), 64'h0077_7234);
    xlate(32'h0000_1234, 1'b1, 0, pa, f, io, pls, lat);
    chk("R8 write denied", 64'(f), 64'd2);
    chk("R11 pulse page", 64'(pls), 64'd1);
  endtask

  task automatic t_segs();
    xlate(32'h1000_0000, 1'b0, 0, pa, f, io, pls, lat);
    chk("R4 invalid segment", 64'(f), 64'd1);
    xlate(32'h4000_0000, 1'b0, 0, pa, f, io, pls, lat);
    chk("R5 bad size code", 64'(f), 64'd1);
    xlate(32'h2003_5678, 1'b1, 0, pa, f, io, pls, lat);
    chk("R5 64K pa", 64'(pa), 64'h0ABC_5678);
    chk("R9 64K ioid", 64'(io), 64'h011);
    xlate(32'h2003_5678, 1'b0, 0, pa, f, io, pls, lat);
    chk("R8 read denied", 64'(f), 64'd2);
    xlate(32'h3123_4567, 1'b0, 0, pa, f, io, pls, lat);
    chk("R5 16M pa", 64'(pa), 64'h2_3F23_4567);
    chk("R9 16M ioid", 64'(io), 64'h7FF);
  endtask

  task automatic t_bounds();
    xlate(32'h0020_0000, 1'b0, 0, pa, f, io, pls, lat);
    chk("R6 index past limit", 64'(f), 64'd2);
    xlate(32'h6020_0010, 1'b1, 0, pa, f, io, pls, lat);
    chk("R6 index within two pages", 64'(f), 64'd0);
    chk("R6 pa", 64'(pa), 64'h0099_9010);
  endtask

  task automatic t_hold_rewrite();
    xlate(32'h1000_0000, 1'b0, 3, pa, f, io, pls, lat);
    chk("R10 held fault", 64'(f), 64'd1);
    wr_tbl(11'd512, 64'hC000_0000_5555_5001);
    xlate(32'h0000_0ABC, 1'b1, 2, pa, f, io, pls, lat);
    chk("R12 rewritten pa", 64'(pa), 64'h5555_5ABC);
    chk("R12 rewritten ioid", 64'(io), 64'h001);
  endtask

  initial begin
    rst_n = 1'b0; reg_we = 0; reg_sel = 0; reg_wdata = 0;
    tbl_we = 0; tbl_waddr = 0; tbl_wdata = 0;
    req_valid = 0; req_addr = 0; req_write = 0; rsp_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_load();
    t_bypass();
    t_origin_off();
    t_4k();
    t_segs();
    t_bounds();
    t_hold_rewrite();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule